// File: doc/BRIEF.md
# Serial Byte Stream to Packet Aggregator

This block sits behind a serial receiver and packs the incoming byte stream into short outbound packets for a bulk transport. Each packet opens with two status bytes and carries between zero and a configurable maximum of data bytes (62 by default). Data bytes are stored in arrival order. A packet is released when one of these happens: the buffer reaches its maximum fill, the latency timer runs out on a partly filled buffer, a byte matches a programmable event character, or a modem status line changes level.

Packet starts are spaced by a service window that is measured in ticks of a millisecond strobe. A trigger that arrives inside the window is held and served as soon as the window closes. Storage is two alternating buffers. While one buffer is being sent, new bytes go into the other. A byte that arrives when the filling buffer is full and cannot yet be swapped out is dropped, and the next packet reports the loss in its second status byte.

The packet side is a byte-per-cycle stream with start and last markers. It has no back-pressure.

Top module: `ser_pkt_agg`

## Requirements
- R1: A packet is sent on consecutive cycles. Its first byte is status byte 0, marked with `pk_sof`. Its second byte is status byte 1. The buffered data bytes follow in arrival order, and the last byte is marked with `pk_eof`. Total length is data count + 2.
- R2: When the buffer reaches `DATA_MAX` data bytes it is flushed without waiting for any other trigger. A buffer holding one byte fewer is not flushed by fill level.
- R3: When `evt_en` is 1, a byte equal to `evt_char` triggers a flush, and that byte is the last data byte of the packet. When `evt_en` is 0, such a byte is stored as ordinary data and causes no flush.
- R4: With `lat_ms` = L, a buffer that received its first byte after a tick is flushed on the L-th following `ms_tick`, and not before.
- R5: Any change of a `modem_in` line flushes a packet, even one with no data. Status byte 0 holds `modem_in[3:0]` (bit0 CTS, bit1 DSR, bit2 RI, bit3 DCD) in bits 4..7, and bits 0..3 are zero.
- R6: Two packet starts are always separated by at least `SVC_TICKS` ticks. A trigger raised inside that window is kept pending and served after it.
- R7: Bytes that arrive while a packet is being sent are kept and appear in the next packet. No byte is lost while a buffer is free.
- R8: A byte that arrives while both buffers are occupied is discarded. The next packet carries status byte 1 = 0x02 (bit 1 = overrun, all other bits 0), and later packets carry 0x00 again.
- R9: During reset and after it, with no input activity, `pk_valid` stays 0.
- R10: `pk_valid` never drops inside a packet, a new `pk_sof` never appears before the previous `pk_eof`, and at least one idle cycle follows each `pk_eof`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| rx_valid | input | 1 | A received byte is present this cycle |
| rx_data | input | 8 | Received byte |
| modem_in | input | 4 | Modem line levels {DCD, RI, DSR, CTS}, already synchronised |
| evt_char | input | 8 | Event character value |
| evt_en | input | 1 | Enables event character matching |
| lat_ms | input | LAT_W | Latency timeout, in ticks |
| ms_tick | input | 1 | One-cycle millisecond strobe |
| pk_valid | output | 1 | Packet byte valid |
| pk_sof | output | 1 | First byte of a packet |
| pk_eof | output | 1 | Last byte of a packet |
| pk_data | output | 8 | Packet byte |

## Verification
Each internal fault shows up in the packet stream. A wrong fill count or a wrong buffer select produces a packet of the wrong length, or data from the previous packet, within one packet of the fault. A wrong latency or window counter moves a packet start to a different tick, so the bench tags every `pk_sof` with its tick number and checks the early and late boundaries. A lost overrun flag, or one that never clears, is visible in status byte 1 of the next packet or of the one after it.

// File: rtl/pkt_agg_pkg.sv
// Shared types and helpers for the serial-to-packet aggregator.
// Assumes status bytes are fixed at two per packet.
package pkt_agg_pkg;
    typedef logic [7:0] byte_t;

    localparam int STATUS_BYTES = 2;
    localparam int OVR_BIT      = 1;

    // Status byte 0: modem levels in the upper nibble, lower nibble zero.
    function automatic byte_t mk_status0(input logic [3:0] modem);
        return {modem, 4'b0000};
    endfunction

    // Status byte 1: overrun flag at OVR_BIT, other bits zero.
    function automatic byte_t mk_status1(input logic ovr);
        byte_t s;
        s = '0;
        s[OVR_BIT] = ovr;
        return s;
    endfunction
endpackage

// File: rtl/pkt_agg_pingpong.sv
// Two alternating data buffers. One buffer fills while the other is read
// by the emitter. A swap hands the filling buffer to the emitter, and a
// byte written in the same cycle goes to index 0 of the freshly emptied
// buffer. Assumes swap is raised only while the emitter is idle.
module pkt_agg_pingpong #(
    parameter int DATA_MAX = 62,
    localparam int CW   = $clog2(DATA_MAX + 1),
    localparam int IDXW = (DATA_MAX > 1) ? $clog2(DATA_MAX) : 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic [7:0]      wr_data,
    input  logic            swap,
    input  logic [IDXW-1:0] rd_idx,
    output logic [7:0]      rd_data,
    output logic [CW-1:0]   fill_cnt,
    output logic            wr_done,
    output logic            full_hit,
    output logic            drop
);
    logic [7:0]      mem [2][DATA_MAX];
    logic            fill_sel;
    logic            room;
    logic            wr_sel;
    logic [IDXW-1:0] wr_idx;
    logic [CW-1:0]   next_cnt;

    // Work out where an incoming byte lands and whether it fits.
    always_comb begin
        room     = swap || (fill_cnt < CW'(DATA_MAX));
        wr_done  = wr_en && room;
        drop     = wr_en && !room;
        wr_sel   = swap ? ~fill_sel : fill_sel;
        wr_idx   = swap ? '0 : IDXW'(fill_cnt);
        next_cnt = swap ? CW'(1) : fill_cnt + CW'(1);
        full_hit = wr_done && (next_cnt == CW'(DATA_MAX));
    end

    // Track the filling buffer and its count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fill_sel <= 1'b0;
            fill_cnt <= '0;
        end else if (swap) begin
            fill_sel <= ~fill_sel;
            fill_cnt <= wr_done ? CW'(1) : '0;
        end else if (wr_done) begin
            fill_cnt <= fill_cnt + CW'(1);
        end
    end

    // Store accepted bytes; contents need no reset.
    always_ff @(posedge clk) begin
        if (wr_done) mem[wr_sel][wr_idx] <= wr_data;
    end

    // The emitter reads the buffer that is not filling.
    assign rd_data = mem[~fill_sel][rd_idx];

    p_fill_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
        fill_cnt <= CW'(DATA_MAX));
    p_swap_empty_r7: assert property (@(posedge clk) disable iff (!rst_n)
        swap |=> fill_cnt <= CW'(1));
endmodule

// File: rtl/pkt_agg_trig.sv
// Flush decision. Collects fill, event, latency and modem-change triggers
// into a pending flag, and releases a start once the service window has
// closed and the emitter is idle. Assumes ms_tick is a one-cycle strobe
// and SVC_TICKS is at least 1.
module pkt_agg_trig #(
    parameter int SVC_TICKS = 1,
    parameter int LAT_W     = 8,
    parameter int CW        = 6,
    localparam int WW = $clog2(SVC_TICKS + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ms_tick,
    input  logic [LAT_W-1:0] lat_ms,
    input  logic [3:0]       modem_in,
    input  logic [CW-1:0]    fill_cnt,
    input  logic             full_hit,
    input  logic             evt_hit,
    input  logic             busy,
    output logic             start
);
    logic [3:0]       modem_q;
    logic [LAT_W-1:0] lat_cnt;
    logic [WW-1:0]    win_cnt;
    logic             pend_q;
    logic             win_open;
    logic             mdm_chg;
    logic             lat_hit;
    logic             trig_now;

    // Combine the trigger sources and decide on a start.
    always_comb begin
        win_open = (win_cnt >= WW'(SVC_TICKS));
        start    = pend_q && win_open && !busy;
        mdm_chg  = (modem_in != modem_q);
        lat_hit  = ms_tick && (fill_cnt != '0) &&
                   ((LAT_W+1)'(lat_cnt) + (LAT_W+1)'(1) >= (LAT_W+1)'(lat_ms));
        trig_now = full_hit || evt_hit || mdm_chg || (lat_hit && !start);
    end

    // Hold a pending trigger until it is served.
    always_ff @(posedge clk) begin
        if (!rst_n) pend_q <= 1'b0;
        else        pend_q <= (pend_q && !start) || trig_now;
    end

    // Keep the previous modem levels; reset loads the current levels.
    always_ff @(posedge clk) begin
        modem_q <= modem_in;
    end

    // Latency timer: counts ticks only while data is buffered.
    always_ff @(posedge clk) begin
        if (!rst_n || start || fill_cnt == '0) lat_cnt <= '0;
        else if (ms_tick && lat_cnt != '1)     lat_cnt <= lat_cnt + LAT_W'(1);
    end

    // Service window: counts ticks after each start; open at reset.
    always_ff @(posedge clk) begin
        if (!rst_n)                    win_cnt <= WW'(SVC_TICKS);
        else if (start)                win_cnt <= '0;
        else if (ms_tick && !win_open) win_cnt <= win_cnt + WW'(1);
    end

    p_spacing_r6: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> !start);
    p_no_start_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !start);
endmodule

// File: rtl/pkt_agg_emit.sv
// Packet emitter. On start it latches the length and both status bytes,
// then sends one byte per cycle: status 0, status 1, then data read from
// the buffer. Assumes start arrives only while idle.
module pkt_agg_emit #(
    parameter int DATA_MAX = 62,
    localparam int CW   = $clog2(DATA_MAX + 1),
    localparam int IDXW = (DATA_MAX > 1) ? $clog2(DATA_MAX) : 1,
    localparam int PW   = $clog2(DATA_MAX + 3)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic [CW-1:0]   len,
    input  logic [7:0]      st0,
    input  logic [7:0]      st1,
    input  logic [7:0]      rd_data,
    output logic [IDXW-1:0] rd_idx,
    output logic            busy,
    output logic            pk_valid,
    output logic            pk_sof,
    output logic            pk_eof,
    output logic [7:0]      pk_data
);
    logic [PW-1:0] pos;
    logic [PW-1:0] last_q;
    logic [7:0]    st0_q;
    logic [7:0]    st1_q;

    // Step through the packet positions.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy   <= 1'b0;
            pos    <= '0;
            last_q <= '0;
            st0_q  <= '0;
            st1_q  <= '0;
        end else if (start) begin
            busy   <= 1'b1;
            pos    <= '0;
            last_q <= PW'(len) + PW'(1);
            st0_q  <= st0;
            st1_q  <= st1;
        end else if (busy) begin
            if (pos == last_q) busy <= 1'b0;
            else               pos  <= pos + PW'(1);
        end
    end

    // Select the byte for the current position.
    always_comb begin
        rd_idx   = (pos >= PW'(2)) ? IDXW'(pos - PW'(2)) : '0;
        pk_valid = busy;
        pk_sof   = busy && (pos == '0);
        pk_eof   = busy && (pos == last_q);
        if (pos == '0)          pk_data = st0_q;
        else if (pos == PW'(1)) pk_data = st1_q;
        else                    pk_data = rd_data;
    end

    p_sof_after_start_r1: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> pk_valid && pk_sof);
    p_contig_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (pk_valid && !pk_sof) |-> $past(pk_valid));
    p_gap_after_eof_r10: assert property (@(posedge clk) disable iff (!rst_n)
        pk_eof |=> !pk_valid);
endmodule

// File: rtl/ser_pkt_agg.sv
// Serial-to-packet aggregator top. Wires the ping-pong store, the flush
// decision and the emitter together, and keeps the sticky overrun flag.
// Assumes inputs are synchronous to clk and the receiver gives at most
// one byte per cycle.
module ser_pkt_agg #(
    parameter int DATA_MAX  = 62,
    parameter int SVC_TICKS = 1,
    parameter int LAT_W     = 8,
    localparam int CW   = $clog2(DATA_MAX + 1),
    localparam int IDXW = (DATA_MAX > 1) ? $clog2(DATA_MAX) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rx_valid,
    input  logic [7:0]       rx_data,
    input  logic [3:0]       modem_in,
    input  logic [7:0]       evt_char,
    input  logic             evt_en,
    input  logic [LAT_W-1:0] lat_ms,
    input  logic             ms_tick,
    output logic             pk_valid,
    output logic             pk_sof,
    output logic             pk_eof,
    output logic [7:0]       pk_data
);
    import pkt_agg_pkg::*;

    logic            start;
    logic            busy;
    logic            wr_done;
    logic            full_hit;
    logic            drop;
    logic            evt_hit;
    logic            ovr_q;
    logic [CW-1:0]   fill_cnt;
    logic [IDXW-1:0] rd_idx;
    logic [7:0]      rd_data;

    // An accepted byte equal to the event character requests a flush.
    assign evt_hit = wr_done && evt_en && (rx_data == evt_char);

    // Sticky overrun flag, handed to the next packet when it starts.
    always_ff @(posedge clk) begin
        if (!rst_n) ovr_q <= 1'b0;
        else        ovr_q <= drop || (ovr_q && !start);
    end

    pkt_agg_pingpong #(.DATA_MAX(DATA_MAX)) u_store (
        .clk(clk), .rst_n(rst_n),
        .wr_en(rx_valid), .wr_data(rx_data), .swap(start),
        .rd_idx(rd_idx), .rd_data(rd_data), .fill_cnt(fill_cnt),
        .wr_done(wr_done), .full_hit(full_hit), .drop(drop)
    );

    pkt_agg_trig #(.SVC_TICKS(SVC_TICKS), .LAT_W(LAT_W), .CW(CW)) u_trig (
        .clk(clk), .rst_n(rst_n),
        .ms_tick(ms_tick), .lat_ms(lat_ms), .modem_in(modem_in),
        .fill_cnt(fill_cnt), .full_hit(full_hit), .evt_hit(evt_hit),
        .busy(busy), .start(start)
    );

    pkt_agg_emit #(.DATA_MAX(DATA_MAX)) u_emit (
        .clk(clk), .rst_n(rst_n),
        .start(start), .len(fill_cnt),
        .st0(mk_status0(modem_in)), .st1(mk_status1(ovr_q)),
        .rd_data(rd_data), .rd_idx(rd_idx), .busy(busy),
        .pk_valid(pk_valid), .pk_sof(pk_sof), .pk_eof(pk_eof), .pk_data(pk_data)
    );

    p_drop_flags_r8: assert property (@(posedge clk) disable iff (!rst_n)
        drop |=> ovr_q);
    p_drop_full_r8: assert property (@(posedge clk) disable iff (!rst_n)
        drop |-> (fill_cnt == CW'(DATA_MAX)));
endmodule

// File: tb/ser_pkt_agg_tb.sv
// Self-checking bench on a small configuration (8 data bytes, 1-tick window).
module ser_pkt_agg_tb;
    localparam int DMAX = 8;
    localparam int LW   = 8;
    localparam int TICK = 200;
    localparam logic [7:0] EVC = 8'h7E;

    logic clk = 0, rst_n = 0, rx_valid = 0, evt_en = 1, ms_tick = 0;
    logic [7:0] rx_data = 0, evt_char = EVC;
    logic [3:0] modem_in = 0;
    logic [LW-1:0] lat_ms = 200;
    logic pk_valid, pk_sof, pk_eof;
    logic [7:0] pk_data;

    ser_pkt_agg #(.DATA_MAX(DMAX), .SVC_TICKS(1), .LAT_W(LW)) u_dut (
        .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_data(rx_data),
        .modem_in(modem_in), .evt_char(evt_char), .evt_en(evt_en),
        .lat_ms(lat_ms), .ms_tick(ms_tick), .pk_valid(pk_valid),
        .pk_sof(pk_sof), .pk_eof(pk_eof), .pk_data(pk_data));

    always #5 clk = ~clk;

    int total = 0, fails = 0, tick_no = 0, done = 0;
    int n_pk = 0, cur = 0, in_pkt = 0, mon_err = 0, chk = 0;
    int ns = 0, rd_ptr = 0;
    logic [7:0] pb [64][DMAX+2];
    int pl [64];
    int ptk [64];
    logic [7:0] sent [512];
    logic [7:0] dv = 8'h01;

    // Millisecond strobe.
    initial begin
        forever begin
            repeat (TICK-1) @(negedge clk);
            ms_tick = 1; tick_no++;
            @(negedge clk);
            ms_tick = 0;
        end
    end

    // Packet monitor, sampling on the falling edge.
    always @(negedge clk) begin
        if (rst_n && pk_valid) begin
            if (pk_sof) begin
                if (in_pkt != 0) mon_err++;
                cur = 0; in_pkt = 1;
                if (n_pk < 64) ptk[n_pk] = tick_no;
            end else if (in_pkt == 0) mon_err++;
            if (cur < DMAX+2 && n_pk < 64) pb[n_pk][cur] = pk_data;
            cur++;
            if (pk_eof) begin
                if (n_pk < 64) pl[n_pk] = cur;
                n_pk++; in_pkt = 0;
            end
        end else if (rst_n && in_pkt != 0) mon_err++;
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic nxt();
        dv = dv + 8'h01;
        if (dv == EVC || dv == 8'h00) dv = 8'h01;
    endtask

    task automatic send(input logic [7:0] b, input bit keep);
        @(negedge clk);
        rx_valid = 1; rx_data = b;
        if (keep) begin sent[ns] = b; ns++; end
    endtask

    task automatic idle(input int k);
        @(negedge clk); rx_valid = 0;
        repeat (k) @(negedge clk);
    endtask

    task automatic wait_tick();
        @(negedge ms_tick);
    endtask

    task automatic check_pkt(input int elen, input int e0, input int e1, input string tag);
        int bad;
        bad = -1;
        check(n_pk > chk, {tag, " packet present"}, n_pk, chk+1);
        if (n_pk > chk) begin
            check(pl[chk] == elen, {tag, " length"}, pl[chk], elen);
            check(pb[chk][0] == 8'(e0), {tag, " status0"}, pb[chk][0], e0);
            check(pb[chk][1] == 8'(e1), {tag, " status1"}, pb[chk][1], e1);
            for (int i = 0; i < elen-2 && i < DMAX; i++)
                if (bad < 0 && pb[chk][i+2] != sent[rd_ptr+i]) bad = i;
            if (bad >= 0)
                check(0, {tag, " data order"}, pb[chk][bad+2], sent[rd_ptr+bad]);
            else
                check(1, {tag, " data order"}, 0, 0);
            rd_ptr += elen - 2;
            chk++;
        end
    endtask

    // Watchdog.
    initial begin
        repeat (150000) @(posedge clk);
        if (done == 0) begin
            total++; fails++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

    initial begin
        int p0;
        // R9: quiet through and after reset
        repeat (5) @(negedge clk);
        check(pk_valid == 0, "R9 in reset", pk_valid, 0);
        rst_n = 1;
        repeat (30) @(negedge clk);
        check(n_pk == 0 && pk_valid == 0, "R9 after reset", n_pk, 0);

        // R3/R1: event character sweep over every fill below the maximum
        for (int n = 1; n < DMAX; n++) begin
            wait_tick();
            for (int i = 0; i < n-1; i++) begin send(dv, 1); nxt(); end
            send(EVC, 1);
            idle(20);
            check_pkt(n+2, 0, 0, "R3 R1 event flush");
        end

        // R2: full buffer flush, and no flush one byte short
        wait_tick();
        p0 = n_pk;
        for (int i = 0; i < DMAX-1; i++) begin send(dv, 1); nxt(); end
        idle(10);
        check(n_pk == p0, "R2 no flush one short", n_pk, p0);
        send(dv, 1); nxt();
        idle(20);
        check_pkt(DMAX+2, 0, 0, "R2 full flush");

        // R5: each modem line raises then lowers, status byte 0 follows
        for (int b = 0; b < 8; b++) begin
            wait_tick();
            modem_in = modem_in ^ (4'b0001 << (b % 4));
            idle(10);
            check_pkt(2, {modem_in, 4'b0000}, 0, "R5 modem change");
        end

        // R4: latency sweep, not early and on time
        for (int L = 1; L <= 4; L++) begin
            lat_ms = LW'(L);
            wait_tick();
            send(dv, 1); nxt(); send(dv, 1); nxt();
            idle(2);
            p0 = n_pk;
            for (int k = 0; k < L-1; k++) wait_tick();
            repeat (10) @(negedge clk);
            check(n_pk == p0, "R4 not early", n_pk, p0);
            wait_tick();
            repeat (10) @(negedge clk);
            check_pkt(4, 0, 0, "R4 latency flush");
        end

        // R3: event character ignored when disabled (latency flushes it)
        evt_en = 0; lat_ms = 3;
        wait_tick();
        send(dv, 1); nxt(); send(EVC, 1); send(dv, 1); nxt();
        idle(2);
        p0 = n_pk;
        wait_tick(); wait_tick();
        repeat (10) @(negedge clk);
        check(n_pk == p0, "R3 disabled no flush", n_pk, p0);
        wait_tick();
        repeat (10) @(negedge clk);
        check_pkt(5, 0, 0, "R3 disabled byte kept");
        evt_en = 1; lat_ms = 200;

        // R6/R7/R8: flush, refill during emission, overflow while window closed
        wait_tick();
        p0 = n_pk;
        for (int i = 0; i < 3; i++) begin send(dv, 1); nxt(); end
        send(EVC, 1);
        for (int i = 0; i < DMAX; i++) begin send(dv, 1); nxt(); end
        send(8'hA5, 0); send(8'h5A, 0);
        idle(20);
        check(n_pk == p0 + 1, "R6 pending held in window", n_pk, p0 + 1);
        wait_tick();
        repeat (20) @(negedge clk);
        check_pkt(6, {modem_in, 4'b0000}, 0, "R7 first half");
        check_pkt(DMAX+2, {modem_in, 4'b0000}, 2, "R8 R7 overrun packet");
        if (n_pk > p0 + 1)
            check(ptk[p0+1] > ptk[p0], "R6 spacing", ptk[p0+1], ptk[p0] + 1);
        wait_tick();
        modem_in = modem_in ^ 4'b0001;
        idle(10);
        check_pkt(2, {modem_in, 4'b0000}, 0, "R8 flag cleared");

        check(mon_err == 0, "R10 framing", mon_err, 0);
        done = 1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule